// File: doc/BRIEF.md
# Serial Display Command Receiver

This block accepts display commands from a host over three wires: a select line, a shift clock and a data line. While select is high, each rising shift-clock edge pushes one data bit into a history register that always holds the most recent 59 bits. When select drops, the block reads the three newest bits as a command code. It then copies the bits just ahead of that code into one of its output stores. There are three 56-bit segment banks, a broadcast form that fills all three banks together, and a 10-bit brightness level.

The three serial inputs are asynchronous to the system clock. They pass through a synchroniser, and edges are detected on the synchronised copies. Segment frames carry 56 payload bits and brightness frames carry 10. Both share the single history register, because the payload is always taken from fixed positions counted back from the newest bit. The outputs are plain registered levels that downstream display-multiplexing and brightness-pulse logic read directly.

Top module: `serial_display_rx`

## Requirements
- R1: A data bit enters the history only on a rising shift-clock edge seen while select is high. Shift-clock edges while select is low leave the history untouched. The history keeps the latest 59 bits.
- R2: Outputs change only on the load strobe made from a falling edge of select. The new value is visible three system clocks after select falls (two synchroniser stages plus edge detection).
- R3: Command code 0 writes the same 56-bit segment payload into banks A, B and C. The n-th bit of a segment frame (n = 1..56) lands at bit n-1 of the bank.
- R4: Command codes 1, 2 and 3 write the segment payload into bank A, B or C respectively and leave the other two banks and the brightness level unchanged.
- R5: Command code 4 writes the 10-bit brightness level. The first brightness bit sent is bit 0 (LSB). The payload is the 10 bits received just before the code, and the segment banks are unchanged.
- R6: Command codes 5, 6 and 7 change no output.
- R7: Reset (rstN low) clears the history, all three segment banks and the brightness level to zero.
- R8: The command code is the last three bits received, the first of them being code bit 0. A frame of any length loads, taking its payload from the fixed positions before the code, including bits left from earlier frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| csIn | input | 1 | Serial select from host, high while a frame is sent |
| sclkIn | input | 1 | Serial shift clock, data taken on its rising edge |
| sdatIn | input | 1 | Serial data bit |
| segBankA | output | 56 | Segment bank for the first grid; bit n-1 is segment n, 1 = lit |
| segBankB | output | 56 | Segment bank for the second grid |
| segBankC | output | 56 | Segment bank for the third grid |
| dimLevel | output | 10 | Brightness level |

## Verification
The properties assume the host never sends a shift-clock rising edge in the same synchronised cycle as a select transition. Without that, a bit could be shifted and loaded together. They also assume data is settled before the shift clock rises, so that data and clock, delayed equally, are read consistently. The stimulus keeps every serial level steady for four system clocks. It opens select four clocks before the first shift edge and closes it four clocks after the last. Frames are spaced ten clocks apart, so every load completes before the next frame begins.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  localparam int SegWidth  = 56;
  localparam int DimWidth  = 10;
  localparam int ModeWidth = 3;
  localparam int BankCount = 3;

  // strobes handed from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic serBit;
  } rxStrobe_t;

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      sclkIn,
  input  logic      sdatIn,
  output rxStrobe_t strb
);

  localparam int PinCount = 3;
  localparam int PinCs    = 0;
  localparam int PinSclk  = 1;
  localparam int PinData  = 2;

  logic [PinCount-1:0] rawPins;
  logic [PinCount-1:0] syncPins;
  logic csPrev;
  logic sclkPrev;
  logic csNow;
  logic sclkNow;

  assign rawPins[PinCs]   = csIn;
  assign rawPins[PinSclk] = sclkIn;
  assign rawPins[PinData] = sdatIn;

  // data passes through the same depth as the clock so they stay aligned
  sdr_sync #(
    .WIDTH  (PinCount),
    .STAGES (SYNC_STAGES)
  ) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawPins),
    .syncOut (syncPins)
  );

  assign csNow   = syncPins[PinCs];
  assign sclkNow = syncPins[PinSclk];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csNow;
      sclkPrev <= sclkNow;
    end
  end

  always_comb begin
    strb.shiftEn = sclkNow & ~sclkPrev & csNow;
    strb.loadEn  = csPrev & ~csNow;
    strb.serBit  = syncPins[PinData];
  end

endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath
  import sdr_pkg::*;
#(
  parameter int SEG_W  = SegWidth,
  parameter int DIM_W  = DimWidth,
  parameter int MODE_W = ModeWidth,
  parameter int BANKS  = BankCount
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rxStrobe_t                   strb,
  output logic [BANKS-1:0][SEG_W-1:0] segAll,
  output logic [DIM_W-1:0]            dimLevel,
  output logic [MODE_W-1:0]           modeCode
);

  localparam int HistWidth = SEG_W + MODE_W;
  localparam int DimTop    = MODE_W + DIM_W - 1;
  localparam int DimCode   = BANKS + 1;

  logic [HistWidth-1:0] histReg;
  logic [SEG_W-1:0]     segPayload;
  logic [DIM_W-1:0]     dimPayload;
  logic [BANKS-1:0]     bankWe;
  logic                 dimWe;

  // history: newest bit at index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg <= '0;
    end else if (strb.shiftEn) begin
      histReg <= {histReg[HistWidth-2:0], strb.serBit};
    end
  end

  // code bit 0 is the oldest of the last three bits received
  for (genvar m = 0; m < MODE_W; m++) begin : gModeBit
    assign modeCode[m] = histReg[MODE_W-1-m];
  end

  // first segment bit sent is the oldest bit held
  for (genvar i = 0; i < SEG_W; i++) begin : gSegBit
    assign segPayload[i] = histReg[HistWidth-1-i];
  end

  // first brightness bit sent is the LSB
  for (genvar j = 0; j < DIM_W; j++) begin : gDimBit
    assign dimPayload[j] = histReg[DimTop-j];
  end

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    assign bankWe[b] = strb.loadEn &&
                       ((modeCode == '0) || (modeCode == MODE_W'(b + 1)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segAll[b] <= '0;
      end else if (bankWe[b]) begin
        segAll[b] <= segPayload;
      end
    end
  end

  assign dimWe = strb.loadEn && (modeCode == MODE_W'(DimCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dimLevel <= '0;
    end else if (dimWe) begin
      dimLevel <= dimPayload;
    end
  end

endmodule

// File: rtl/serial_display_rx.sv
module serial_display_rx
  import sdr_pkg::*;
#(
  parameter int SEG_W       = SegWidth,
  parameter int DIM_W       = DimWidth,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             sclkIn,
  input  logic             sdatIn,
  output logic [SEG_W-1:0] segBankA,
  output logic [SEG_W-1:0] segBankB,
  output logic [SEG_W-1:0] segBankC,
  output logic [DIM_W-1:0] dimLevel
);

  localparam int Banks = 3;

  rxStrobe_t                   strb;
  logic [Banks-1:0][SEG_W-1:0] segAll;
  logic [ModeWidth-1:0]        modeCode;

  sdr_ctrl #(
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .csIn   (csIn),
    .sclkIn (sclkIn),
    .sdatIn (sdatIn),
    .strb   (strb)
  );

  sdr_datapath #(
    .SEG_W  (SEG_W),
    .DIM_W  (DIM_W),
    .MODE_W (ModeWidth),
    .BANKS  (Banks)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .segAll   (segAll),
    .dimLevel (dimLevel),
    .modeCode (modeCode)
  );

  assign segBankA = segAll[0];
  assign segBankB = segAll[1];
  assign segBankC = segAll[2];

endmodule

// File: rtl/sdr_checker.sv
module sdr_checker
  import sdr_pkg::*;
#(
  parameter int SEG_W = SegWidth,
  parameter int DIM_W = DimWidth
) (
  input logic             clk,
  input logic             rstN,
  input rxStrobe_t        strb,
  input logic [2:0]       modeCode,
  input logic [SEG_W-1:0] segBankA,
  input logic [SEG_W-1:0] segBankB,
  input logic [SEG_W-1:0] segBankC,
  input logic [DIM_W-1:0] dimLevel
);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (segBankA == '0 && segBankB == '0 && segBankC == '0 && dimLevel == '0));

  // R2
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> ($stable(segBankA) && $stable(segBankB) &&
                      $stable(segBankC) && $stable(dimLevel)));

  // R2
  single_load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> !strb.loadEn);

  // R1
  no_shift_at_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |-> !strb.shiftEn);

  // R3
  broadcast_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && modeCode == 3'd0) |=>
      (segBankA == segBankB && segBankB == segBankC));

  // R4
  bank_a_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && modeCode == 3'd1) |=>
      ($stable(segBankB) && $stable(segBankC) && $stable(dimLevel)));

  // R4
  bank_c_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && modeCode == 3'd3) |=>
      ($stable(segBankA) && $stable(segBankB) && $stable(dimLevel)));

  // R5
  dim_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && modeCode == 3'd4) |=>
      ($stable(segBankA) && $stable(segBankB) && $stable(segBankC)));

  // R6
  unused_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && modeCode >= 3'd5) |=>
      ($stable(segBankA) && $stable(segBankB) &&
       $stable(segBankC) && $stable(dimLevel)));

endmodule

bind serial_display_rx sdr_checker #(
  .SEG_W (SEG_W),
  .DIM_W (DIM_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .modeCode (modeCode),
  .segBankA (segBankA),
  .segBankB (segBankB),
  .segBankC (segBankC),
  .dimLevel (dimLevel)
);

// File: tb/sim_serial_display_rx.sv
`timescale 1ns/1ps
module sim_serial_display_rx;

  localparam int SegW = 56;
  localparam int DimW = 10;
  localparam int HistW = 59;
  localparam int LoadLatency = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic sclkIn = 1'b0;
  logic sdatIn = 1'b0;
  logic [SegW-1:0] segBankA, segBankB, segBankC;
  logic [DimW-1:0] dimLevel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit comparing = 0;

  // reference model state
  bit histQ[$];
  logic [SegW-1:0] expA = '0, expB = '0, expC = '0;
  logic [DimW-1:0] expDim = '0;
  logic [SegW-1:0] nxtA, nxtB, nxtC;
  logic [DimW-1:0] nxtDim;
  bit pend = 0;
  int pendDue = 0;

  always #10 clk = ~clk;

  serial_display_rx u0 (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdatIn(sdatIn),
    .segBankA(segBankA), .segBankB(segBankB), .segBankC(segBankC),
    .dimLevel(dimLevel)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (pend && cyc >= pendDue) begin
      expA = nxtA; expB = nxtB; expC = nxtC; expDim = nxtDim;
      pend = 0;
    end
    if (comparing) begin
      check("R2", "bankA per-clock", 64'(segBankA), 64'(expA));
      check("R2", "bankB per-clock", 64'(segBankB), 64'(expB));
      check("R2", "bankC per-clock", 64'(segBankC), 64'(expC));
      check("R2", "dim per-clock", 64'(dimLevel), 64'(expDim));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    sdatIn = b;
    tick(4);
    sclkIn = 1'b1;
    if (csIn) begin
      histQ.push_back(b);
      void'(histQ.pop_front());
    end
    tick(4);
    sclkIn = 1'b0;
  endtask

  // model of the load at select fall
  task automatic dropCs();
    int code;
    csIn = 1'b0;
    code = {histQ[HistW-1], histQ[HistW-2], histQ[HistW-3]};
    nxtA = expA; nxtB = expB; nxtC = expC; nxtDim = expDim;
    for (int n = 0; n < SegW; n++) begin
      if (code == 0 || code == 1) nxtA[n] = histQ[n];
      if (code == 0 || code == 2) nxtB[n] = histQ[n];
      if (code == 0 || code == 3) nxtC[n] = histQ[n];
    end
    if (code == 4) begin
      for (int j = 0; j < DimW; j++) nxtDim[j] = histQ[HistW - 3 - DimW + j];
    end
    pendDue = cyc + LoadLatency;
    pend = 1;
    tick(10);
  endtask

  task automatic sendFrame(bit bits[$]);
    csIn = 1'b1;
    tick(4);
    foreach (bits[k]) sendBit(bits[k]);
    tick(4);
    dropCs();
  endtask

  task automatic segFrame(logic [SegW-1:0] segs, int code);
    bit q[$];
    for (int n = 0; n < SegW; n++) q.push_back(segs[n]);
    for (int m = 0; m < 3; m++) q.push_back(code[m]);
    sendFrame(q);
  endtask

  task automatic dimFrame(logic [DimW-1:0] lvl);
    bit q[$];
    for (int j = 0; j < DimW; j++) q.push_back(lvl[j]);
    q.push_back(0); q.push_back(0); q.push_back(1);
    sendFrame(q);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [SegW-1:0] p1, p2, p3, p4, p5, aSave, bSave;
    for (int i = 0; i < HistW; i++) histQ.push_back(0);
    p1 = 56'hA5_0F33_CC12_3456;
    p2 = 56'h0123_4567_89AB_CD;
    p3 = 56'hFFFF_0000_F0F0_81;
    p4 = 56'h5A5A_C3C3_0FF0_77;
    p5 = 56'hDEAD_BEEF_1357_9B;

    tick(3);
    check("R7", "bankA in reset", 64'(segBankA), 64'h0);
    check("R7", "bankB in reset", 64'(segBankB), 64'h0);
    check("R7", "bankC in reset", 64'(segBankC), 64'h0);
    check("R7", "dim in reset", 64'(dimLevel), 64'h0);
    rstN = 1'b1;
    tick(2);
    comparing = 1;

    // R4 single banks, R3 bit map
    segFrame(p1, 1);
    check("R4", "bankA after code1", 64'(segBankA), 64'(p1));
    check("R4", "bankB untouched by code1", 64'(segBankB), 64'h0);
    check("R3", "segment 1 at bit 0", 64'(segBankA[0]), 64'(p1[0]));
    segFrame(p2, 2);
    check("R4", "bankB after code2", 64'(segBankB), 64'(p2));
    segFrame(p3, 3);
    check("R4", "bankC after code3", 64'(segBankC), 64'(p3));
    check("R4", "bankA kept", 64'(segBankA), 64'(p1));

    // R3 broadcast
    segFrame(p4, 0);
    check("R3", "bankA broadcast", 64'(segBankA), 64'(p4));
    check("R3", "bankB broadcast", 64'(segBankB), 64'(p4));
    check("R3", "bankC broadcast", 64'(segBankC), 64'(p4));

    // R5 brightness
    dimFrame(10'h2A5);
    check("R5", "dim 2A5", 64'(dimLevel), 64'h2A5);
    check("R5", "banks kept by dim", 64'(segBankB), 64'(p4));
    dimFrame(10'h3FF);
    check("R5", "dim 3FF", 64'(dimLevel), 64'h3FF);
    dimFrame(10'h001);
    check("R5", "dim LSB first", 64'(dimLevel), 64'h001);

    // R6 unused codes
    for (int c = 5; c < 8; c++) begin
      segFrame(p5, c);
      check("R6", "bankA under unused code", 64'(segBankA), 64'(p4));
      check("R6", "dim under unused code", 64'(dimLevel), 64'h001);
    end

    // R1 clocks with select low are ignored
    segFrame(p1, 1);
    aSave = segBankA;
    bSave = segBankB;
    for (int k = 0; k < 12; k++) sendBit(0);
    csIn = 1'b1;
    tick(4);
    dropCs();
    check("R1", "bankA after empty reload", 64'(segBankA), 64'(aSave));
    check("R1", "bankB not broadcast", 64'(segBankB), 64'(bSave));

    // R8 short segment frame loads history-padded payload
    begin
      bit q[$];
      for (int k = 0; k < 20; k++) q.push_back(k[0]);
      q.push_back(0); q.push_back(1); q.push_back(0);
      sendFrame(q);
    end
    check("R8", "bankB from short frame", 64'(segBankB), 64'(expB));
    check("R8", "bankB changed", 64'(segBankB != bSave), 64'h1);
    segFrame(p2, 2);
    dimFrame(10'h155);
    check("R8", "dim after long frame", 64'(dimLevel), 64'h155);

    comparing = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule